// File: doc/BRIEF.md
# Ring-Buffer Command FIFO Controller

This block keeps the bookkeeping for a circular command buffer that lives in external memory. It holds a write pointer, a read pointer and a pending-byte count as 32-bit byte addresses inside a window that software programs with a base and a top address. A producer reports each command unit it has stored, and a consumer asks for permission to fetch one. Each accepted operation moves the matching pointer by a fixed step and wraps it inside the window.

Software reaches every setting through a 16-bit register bus. Each 32-bit value is split into a low and a high half, and only a completed pair is committed. Three sticky events are kept for software: an overflow when the count climbs above a high mark, an underflow when it falls below a low mark, and a breakpoint when the read pointer lands on a programmed address. A pending breakpoint halts the consumer and drives an interrupt line until software clears it.

Top module: `cmd_ring_ctrl`

## Requirements
- R1: The 32-bit values are register pairs at byte offset 0x20 + 4*k, with the low half at +0 and the high half at +2. The pair index k is 0 base, 1 top, 2 high mark, 3 low mark, 4 count, 5 write pointer, 6 read pointer, 7 breakpoint. Writing the low half only stages it, and reads still return the old value. A high-half write commits {high, staged low} at that clock edge, but only if a low half was staged since the last commit. Otherwise the high-half write is dropped.
- R2: The control register sits at 0x02. Its bits are 0 read enable, 2 high-mark check, 3 low-mark check, 4 producer link and 5 breakpoint check. These bits read back as written. Bit 1 is a clear strobe and always reads 0. All other control bits read 0.
- R3: A producer pulse (`prod_wr_i`) advances the write pointer by STEP bytes and raises the count by STEP, but only when the link bit is set. When the link bit is clear, the pulse has no effect.
- R4: A consumer request is accepted (`cons_ack_o` high in the same cycle) only when read enable is set, the count is non-zero and no breakpoint is pending. An accepted request advances the read pointer by STEP and lowers the count by STEP.
- R5: A pointer whose next value would reach or pass the top address is loaded with the base address instead.
- R6: Committing a write or read pointer reloads the count with (write - read) modulo (top - base). Committing the count pair loads the written value directly.
- R7: When the high-mark check is enabled and the count is greater than the high mark, status bit 0 (overflow) is set one cycle later. It then stays set until 1 is written to bit 0 of the clear register at 0x04.
- R8: When the low-mark check is enabled and the count is below the low mark, status bit 1 (underflow) is set one cycle later. It then stays set until 1 is written to bit 1 of the clear register. Writing zeros to the clear register changes nothing.
- R9: With the breakpoint check and read enable both set, an accepted read that moves the read pointer onto the breakpoint address sets status bit 4 and `irq_o` at that edge. While that flag is pending, reads stall. Only writing 1 to control bit 1 clears it.
- R10: The status register sits at 0x00. Bit 2 is set when the count is zero. Bit 3 is set when the consumer has nothing it may fetch (count zero, read enable off, or breakpoint pending). Bits 15:5 read 0.
- R11: After reset, all pointers, marks, the count, control and flags are zero, so the status reads 0x000C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 6 | Register byte offset |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data for `reg_addr_i` (combinational) |
| prod_wr_i | input | 1 | Producer stored one unit |
| cons_rd_i | input | 1 | Consumer requests one unit |
| cons_ack_o | output | 1 | Consumer request accepted this cycle |
| irq_o | output | 1 | Breakpoint interrupt pending |

## Verification
Register readback and `cons_ack_o` are combinational, so the bench samples them a moment after driving the address or request, before the next edge. Pair commits, control writes, pointer moves and count updates land on the edge that takes the strobe. The bench therefore reads those values back at the falling edge that follows. Overflow and underflow are derived from the registered count and appear one edge after it. The bench idles one extra cycle before reading status for those flags. The breakpoint flag is set on the same edge as the read that triggers it.

// File: rtl/cmd_ring_pkg.sv
package cmd_ring_pkg;
  localparam logic [5:0] OFS_STAT = 6'h00;
  localparam logic [5:0] OFS_CTRL = 6'h02;
  localparam logic [5:0] OFS_CLR  = 6'h04;

  localparam int NPAIR = 8;
  localparam int PR_BASE = 0;
  localparam int PR_TOP  = 1;
  localparam int PR_HIWM = 2;
  localparam int PR_LOWM = 3;
  localparam int PR_CNT  = 4;
  localparam int PR_WR   = 5;
  localparam int PR_RD   = 6;
  localparam int PR_BP   = 7;

  localparam int CB_RD_EN  = 0;
  localparam int CB_BP_CLR = 1;
  localparam int CB_HI_EN  = 2;
  localparam int CB_LO_EN  = 3;
  localparam int CB_LINK   = 4;
  localparam int CB_BP_EN  = 5;
  localparam int CTRL_W    = 6;
  localparam logic [CTRL_W-1:0] CTRL_KEEP = 6'b11_1101;
endpackage

// File: rtl/cmd_ring_half_pair.sv
module cmd_ring_half_pair #(
  parameter int REG_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               lo_we_i,
  input  logic               hi_we_i,
  input  logic [REG_W-1:0]   wdata_i,
  output logic               commit_o,
  output logic [2*REG_W-1:0] value_o
);
  logic [REG_W-1:0] stage_q;
  logic             lo_seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q   <= '0;
      lo_seen_q <= 1'b0;
    end else begin
      if (lo_we_i) begin
        stage_q   <= wdata_i;
        lo_seen_q <= 1'b1;
      end else if (hi_we_i) begin
        lo_seen_q <= 1'b0;
      end
    end
  end

  // high half without a fresh low half is dropped
  assign commit_o = hi_we_i && lo_seen_q;
  assign value_o  = {wdata_i, stage_q};
endmodule

// File: rtl/cmd_ring_ptr.sv
module cmd_ring_ptr #(
  parameter int AW   = 32,
  parameter int STEP = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] top_i,
  input  logic          wr_commit_i,
  input  logic [AW-1:0] wr_val_i,
  input  logic          rd_commit_i,
  input  logic [AW-1:0] rd_val_i,
  input  logic          cnt_commit_i,
  input  logic [AW-1:0] cnt_val_i,
  input  logic          prod_wr_i,
  input  logic          link_i,
  input  logic          cons_rd_i,
  input  logic          rd_en_i,
  input  logic          stall_i,
  output logic [AW-1:0] wr_o,
  output logic [AW-1:0] rd_o,
  output logic [AW-1:0] cnt_o,
  output logic [AW-1:0] rd_next_o,
  output logic          acc_o
);
  localparam logic [AW-1:0] STEP_V = AW'(STEP);

  logic [AW-1:0] wr_q, rd_q, cnt_q;
  logic [AW-1:0] wr_n, rd_n, cnt_n, wr_adv, rd_adv;
  logic          prod_adv, acc;

  function automatic logic [AW-1:0] advance(input logic [AW-1:0] p,
                                            input logic [AW-1:0] lo,
                                            input logic [AW-1:0] hi);
    logic [AW-1:0] n;
    n = p + STEP_V;
    return (n >= hi) ? lo : n;
  endfunction

  function automatic logic [AW-1:0] distance(input logic [AW-1:0] w,
                                             input logic [AW-1:0] r,
                                             input logic [AW-1:0] lo,
                                             input logic [AW-1:0] hi);
    return (w >= r) ? (w - r) : (w - r + (hi - lo));
  endfunction

  assign prod_adv = prod_wr_i && link_i;
  assign acc      = cons_rd_i && rd_en_i && !stall_i && (cnt_q != '0);
  assign wr_adv   = advance(wr_q, base_i, top_i);
  assign rd_adv   = advance(rd_q, base_i, top_i);

  always_comb begin
    wr_n = wr_q;
    rd_n = rd_q;
    if (wr_commit_i)   wr_n = wr_val_i;
    else if (prod_adv) wr_n = wr_adv;
    if (rd_commit_i)   rd_n = rd_val_i;
    else if (acc)      rd_n = rd_adv;

    if (cnt_commit_i)                    cnt_n = cnt_val_i;
    else if (wr_commit_i || rd_commit_i) cnt_n = distance(wr_n, rd_n, base_i, top_i);
    else cnt_n = cnt_q + (prod_adv ? STEP_V : '0) - (acc ? STEP_V : '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_n;
      rd_q  <= rd_n;
      cnt_q <= cnt_n;
    end
  end

  assign wr_o      = wr_q;
  assign rd_o      = rd_q;
  assign cnt_o     = cnt_q;
  assign rd_next_o = rd_adv;
  assign acc_o     = acc;

  AST_CNT_DEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && !prod_adv && !wr_commit_i && !rd_commit_i && !cnt_commit_i)
      |=> cnt_q == $past(cnt_q) - STEP_V); // R4

  AST_WR_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prod_adv && !wr_commit_i && (wr_q + STEP_V >= top_i))
      |=> wr_q == $past(base_i)); // R5

  AST_UNLINKED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!link_i && !wr_commit_i) |=> $stable(wr_q)); // R3
endmodule

// File: rtl/cmd_ring_flags.sv
module cmd_ring_flags #(
  parameter int AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] cnt_i,
  input  logic [AW-1:0] hiwm_i,
  input  logic [AW-1:0] lowm_i,
  input  logic          hi_en_i,
  input  logic          lo_en_i,
  input  logic          clr_ovf_i,
  input  logic          clr_unf_i,
  input  logic          bp_set_i,
  input  logic          clr_bp_i,
  output logic          ovf_o,
  output logic          unf_o,
  output logic          bp_o
);
  logic ovf_q, unf_q, bp_q;
  logic ovf_hit, unf_hit;

  assign ovf_hit = hi_en_i && (cnt_i > hiwm_i);
  assign unf_hit = lo_en_i && (cnt_i < lowm_i);

  // clear wins over a same-cycle set
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
      bp_q  <= 1'b0;
    end else begin
      if (clr_ovf_i)    ovf_q <= 1'b0;
      else if (ovf_hit) ovf_q <= 1'b1;
      if (clr_unf_i)    unf_q <= 1'b0;
      else if (unf_hit) unf_q <= 1'b1;
      if (clr_bp_i)      bp_q <= 1'b0;
      else if (bp_set_i) bp_q <= 1'b1;
    end
  end

  assign ovf_o = ovf_q;
  assign unf_o = unf_q;
  assign bp_o  = bp_q;

  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q && !clr_ovf_i) |=> ovf_q); // R7

  AST_UNF_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lo_en_i && (cnt_i < lowm_i) && !clr_unf_i) |=> unf_q); // R8

  AST_BP_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bp_set_i && !clr_bp_i) |=> bp_q); // R9
endmodule

// File: rtl/cmd_ring_ctrl.sv
module cmd_ring_ctrl
  import cmd_ring_pkg::*;
#(
  parameter int REG_W = 16,
  parameter int STEP  = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_wr_i,
  input  logic [5:0]       reg_addr_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  input  logic             prod_wr_i,
  input  logic             cons_rd_i,
  output logic             cons_ack_o,
  output logic             irq_o
);
  localparam int AW = 2 * REG_W;

  logic          pair_wr;
  logic [2:0]    pidx;
  logic          commit [NPAIR];
  logic [AW-1:0] pair_val [NPAIR];
  logic [AW-1:0] view [NPAIR];

  logic [AW-1:0] base_q, top_q, hiwm_q, lowm_q, bp_addr_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic [AW-1:0] wr_ptr, rd_ptr, cnt, rd_next;
  logic          acc, ovf, unf, bp_pend, bp_set;
  logic          clr_ovf, clr_unf, clr_bp, ctrl_we;
  logic          idle_rd, idle_cmd;

  assign pair_wr = reg_wr_i && reg_addr_i[5] && !reg_addr_i[0];
  assign pidx    = reg_addr_i[4:2];

  for (genvar i = 0; i < NPAIR; i++) begin : g_pair
    cmd_ring_half_pair #(.REG_W(REG_W)) u_pair (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .lo_we_i (pair_wr && (pidx == 3'(i)) && !reg_addr_i[1]),
      .hi_we_i (pair_wr && (pidx == 3'(i)) &&  reg_addr_i[1]),
      .wdata_i (reg_wdata_i),
      .commit_o(commit[i]),
      .value_o (pair_val[i])
    );
  end

  assign ctrl_we = reg_wr_i && (reg_addr_i == OFS_CTRL);
  assign clr_bp  = ctrl_we && reg_wdata_i[CB_BP_CLR];
  assign clr_ovf = reg_wr_i && (reg_addr_i == OFS_CLR) && reg_wdata_i[0];
  assign clr_unf = reg_wr_i && (reg_addr_i == OFS_CLR) && reg_wdata_i[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q    <= '0;
      top_q     <= '0;
      hiwm_q    <= '0;
      lowm_q    <= '0;
      bp_addr_q <= '0;
      ctrl_q    <= '0;
    end else begin
      if (commit[PR_BASE]) base_q    <= pair_val[PR_BASE];
      if (commit[PR_TOP])  top_q     <= pair_val[PR_TOP];
      if (commit[PR_HIWM]) hiwm_q    <= pair_val[PR_HIWM];
      if (commit[PR_LOWM]) lowm_q    <= pair_val[PR_LOWM];
      if (commit[PR_BP])   bp_addr_q <= pair_val[PR_BP];
      if (ctrl_we)         ctrl_q    <= reg_wdata_i[CTRL_W-1:0] & CTRL_KEEP;
    end
  end

  cmd_ring_ptr #(.AW(AW), .STEP(STEP)) u_ptr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .base_i      (base_q),
    .top_i       (top_q),
    .wr_commit_i (commit[PR_WR]),
    .wr_val_i    (pair_val[PR_WR]),
    .rd_commit_i (commit[PR_RD]),
    .rd_val_i    (pair_val[PR_RD]),
    .cnt_commit_i(commit[PR_CNT]),
    .cnt_val_i   (pair_val[PR_CNT]),
    .prod_wr_i   (prod_wr_i),
    .link_i      (ctrl_q[CB_LINK]),
    .cons_rd_i   (cons_rd_i),
    .rd_en_i     (ctrl_q[CB_RD_EN]),
    .stall_i     (bp_pend),
    .wr_o        (wr_ptr),
    .rd_o        (rd_ptr),
    .cnt_o       (cnt),
    .rd_next_o   (rd_next),
    .acc_o       (acc)
  );

  assign bp_set = ctrl_q[CB_BP_EN] && ctrl_q[CB_RD_EN] && acc && (rd_next == bp_addr_q);

  cmd_ring_flags #(.AW(AW)) u_flags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cnt_i    (cnt),
    .hiwm_i   (hiwm_q),
    .lowm_i   (lowm_q),
    .hi_en_i  (ctrl_q[CB_HI_EN]),
    .lo_en_i  (ctrl_q[CB_LO_EN]),
    .clr_ovf_i(clr_ovf),
    .clr_unf_i(clr_unf),
    .bp_set_i (bp_set),
    .clr_bp_i (clr_bp),
    .ovf_o    (ovf),
    .unf_o    (unf),
    .bp_o     (bp_pend)
  );

  assign idle_rd  = (cnt == '0);
  assign idle_cmd = idle_rd || !ctrl_q[CB_RD_EN] || bp_pend;

  always_comb begin
    view[PR_BASE] = base_q;
    view[PR_TOP]  = top_q;
    view[PR_HIWM] = hiwm_q;
    view[PR_LOWM] = lowm_q;
    view[PR_CNT]  = cnt;
    view[PR_WR]   = wr_ptr;
    view[PR_RD]   = rd_ptr;
    view[PR_BP]   = bp_addr_q;
  end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i[5] && !reg_addr_i[0]) begin
      reg_rdata_o = reg_addr_i[1] ? view[pidx][AW-1:REG_W] : view[pidx][REG_W-1:0];
    end else if (reg_addr_i == OFS_STAT) begin
      reg_rdata_o = REG_W'({bp_pend, idle_cmd, idle_rd, unf, ovf});
    end else if (reg_addr_i == OFS_CTRL) begin
      reg_rdata_o = REG_W'(ctrl_q);
    end
  end

  assign cons_ack_o = acc;
  assign irq_o      = bp_pend;

  AST_STALL_ON_BP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> !cons_ack_o); // R9

  AST_ACK_NOT_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cons_ack_o |-> (cnt != '0)); // R4

  AST_RD_ADV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cons_ack_o && !commit[PR_RD]) |=> rd_ptr == $past(rd_next)); // R4
endmodule

// File: tb/cmd_ring_ctrl_test.sv
`timescale 1ns/1ps
module cmd_ring_ctrl_test;
  localparam logic [5:0] A_STAT = 6'h00, A_CTRL = 6'h02, A_CLR = 6'h04;
  localparam logic [5:0] A_BASE = 6'h20, A_TOP = 6'h24, A_HIWM = 6'h28, A_LOWM = 6'h2C;
  localparam logic [5:0] A_CNT = 6'h30, A_WR = 6'h34, A_RD = 6'h38, A_BP = 6'h3C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        prod_wr = 1'b0;
  logic        cons_rd = 1'b0;
  logic        cons_ack;
  logic        irq;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cmd_ring_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .prod_wr_i(prod_wr),
    .cons_rd_i(cons_rd), .cons_ack_o(cons_ack), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic wr16(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic wr32(input logic [5:0] a, input logic [31:0] d);
    wr16(a, d[15:0]);
    wr16(a + 6'd2, d[31:16]);
  endtask

  task automatic rd16(input logic [5:0] a, output logic [15:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic rd32(input logic [5:0] a, output logic [31:0] d);
    logic [15:0] lo, hi;
    rd16(a, lo);
    rd16(a + 6'd2, hi);
    d = {hi, lo};
  endtask

  task automatic push(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); prod_wr = 1'b1;
      @(negedge clk); prod_wr = 1'b0;
    end
  endtask

  task automatic pop(output logic ack);
    @(negedge clk); cons_rd = 1'b1;
    #1 ack = cons_ack;
    @(negedge clk); cons_rd = 1'b0;
  endtask

  task automatic t_reset();
    logic [15:0] d; logic [31:0] v;
    rd16(A_STAT, d); chk("R11 status", 32'(d), 32'h000C);
    rd16(A_CTRL, d); chk("R11 ctrl", 32'(d), 32'h0);
    rd32(A_WR, v);   chk("R11 wrptr", v, 32'h0);
    chk("R11 irq", 32'(irq), 32'h0);
  endtask

  task automatic t_pair();
    logic [15:0] d; logic [31:0] v;
    wr16(A_BASE, 16'h1000);
    rd16(A_BASE, d); chk("R1 low staged only", 32'(d), 32'h0);
    wr16(A_BASE + 6'd2, 16'h0000);
    rd32(A_BASE, v); chk("R1 pair commit", v, 32'h0000_1000);
    wr16(A_BASE + 6'd2, 16'h0005);
    rd32(A_BASE, v); chk("R1 high without low dropped", v, 32'h0000_1000);
    wr32(A_TOP, 32'h1100);
    wr32(A_WR, 32'h1000);
    wr32(A_RD, 32'h1000);
    rd32(A_CNT, v); chk("R6 count after pointer load", v, 32'h0);
    wr16(A_CTRL, 16'hFFFF);
    rd16(A_CTRL, d); chk("R2 ctrl readback", 32'(d), 32'h003D);
    wr16(A_CTRL, 16'h0000);
    rd16(A_STAT, d); chk("R10 status empty", 32'(d), 32'h000C);
  endtask

  task automatic t_link();
    logic [31:0] v;
    wr16(A_CTRL, 16'h0001);
    push(1);
    rd32(A_WR, v); chk("R3 unlinked push ignored", v, 32'h1000);
    rd32(A_CNT, v); chk("R3 unlinked count", v, 32'h0);
    wr16(A_CTRL, 16'h0011);
    push(3);
    rd32(A_WR, v); chk("R3 linked wrptr", v, 32'h1060);
    rd32(A_CNT, v); chk("R3 linked count", v, 32'h60);
  endtask

  task automatic t_read();
    logic a; logic [31:0] v;
    wr16(A_CTRL, 16'h0010);
    pop(a); chk("R4 no ack when disabled", 32'(a), 32'h0);
    rd32(A_RD, v); chk("R4 rdptr held", v, 32'h1000);
    wr16(A_CTRL, 16'h0011);
    pop(a); chk("R4 ack when enabled", 32'(a), 32'h1);
    rd32(A_RD, v); chk("R4 rdptr step", v, 32'h1020);
    rd32(A_CNT, v); chk("R4 count step", v, 32'h40);
  endtask

  task automatic t_wrap();
    logic [31:0] v;
    wr32(A_WR, 32'h10E0);
    rd32(A_CNT, v); chk("R6 count on wr load", v, 32'hC0);
    push(1);
    rd32(A_WR, v); chk("R5 wrptr wraps", v, 32'h1000);
    rd32(A_CNT, v); chk("R5 count after wrap", v, 32'hE0);
    wr32(A_RD, 32'h1080);
    rd32(A_CNT, v); chk("R6 count modulo size", v, 32'h80);
  endtask

  task automatic t_ovf();
    logic [15:0] d;
    wr32(A_HIWM, 32'h40);
    idle();
    rd16(A_STAT, d); chk("R7 no ovf when check off", 32'(d[0]), 32'h0);
    wr16(A_CTRL, 16'h0015);
    idle();
    rd16(A_STAT, d); chk("R7 ovf set", 32'(d[0]), 32'h1);
    wr32(A_HIWM, 32'h100);
    idle();
    rd16(A_STAT, d); chk("R7 ovf sticky", 32'(d[0]), 32'h1);
    wr16(A_CLR, 16'h0002);
    idle();
    rd16(A_STAT, d); chk("R7 other clear bit no effect", 32'(d[0]), 32'h1);
    wr16(A_CLR, 16'h0001);
    idle();
    rd16(A_STAT, d); chk("R7 ovf cleared", 32'(d[0]), 32'h0);
  endtask

  task automatic t_unf();
    logic [15:0] d;
    wr32(A_LOWM, 32'h100);
    wr16(A_CTRL, 16'h001D);
    idle();
    rd16(A_STAT, d); chk("R8 unf set", 32'(d[1]), 32'h1);
    wr32(A_LOWM, 32'h0);
    wr16(A_CLR, 16'h0000);
    idle();
    rd16(A_STAT, d); chk("R8 zero write no effect", 32'(d[1]), 32'h1);
    wr16(A_CLR, 16'h0002);
    idle();
    rd16(A_STAT, d); chk("R8 unf cleared", 32'(d[1]), 32'h0);
    wr16(A_CTRL, 16'h0011);
    rd16(A_STAT, d); chk("R10 status busy", 32'(d), 32'h0000);
  endtask

  task automatic t_drain();
    logic a; logic [15:0] d; logic [31:0] v;
    for (int i = 0; i < 4; i++) begin
      pop(a); chk("R4 drain ack", 32'(a), 32'h1);
    end
    rd32(A_RD, v); chk("R5 rdptr wraps", v, 32'h1000);
    rd32(A_CNT, v); chk("R4 drained count", v, 32'h0);
    rd16(A_STAT, d); chk("R10 idle after drain", 32'(d), 32'h000C);
    pop(a); chk("R4 no ack when empty", 32'(a), 32'h0);
  endtask

  task automatic t_bp();
    logic a; logic [15:0] d; logic [31:0] v;
    push(4);
    wr32(A_BP, 32'h1040);
    wr16(A_CTRL, 16'h0031);
    pop(a); chk("R9 read before bp", 32'(a), 32'h1);
    chk("R9 no irq yet", 32'(irq), 32'h0);
    pop(a); chk("R9 read onto bp", 32'(a), 32'h1);
    chk("R9 irq set", 32'(irq), 32'h1);
    rd16(A_STAT, d); chk("R9 status bp", 32'(d), 32'h0018);
    pop(a); chk("R9 stalled", 32'(a), 32'h0);
    rd32(A_RD, v); chk("R9 rdptr at bp", v, 32'h1040);
    wr16(A_CTRL, 16'h0033);
    chk("R9 irq cleared", 32'(irq), 32'h0);
    rd16(A_CTRL, d); chk("R2 clear bit reads 0", 32'(d), 32'h0031);
    pop(a); chk("R9 resumes", 32'(a), 32'h1);
    rd32(A_RD, v); chk("R9 rdptr past bp", v, 32'h1060);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle();
    t_reset();
    t_pair();
    t_link();
    t_read();
    t_wrap();
    t_ovf();
    t_unf();
    t_drain();
    t_bp();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule